// File: doc/BRIEF.md
# Programmable Pulse and Trigger Counter Engine

This block turns a tunable reference clock into a repeating rectangular output pulse and a companion trigger pulse. A frame counter sets the repetition period in whole clock cycles. A length counter decides how many of those cycles the main output stays high. A delay counter decides when the trigger drops. The falling edge of the trigger is the timing marker, and its width does not matter. Every frame rollover raises the output, raises the trigger and restarts the other two counters in the same cycle. That single event re-aligns the whole frame.

A host loads the three settings over a write-only parallel bus made of a word address, a data word and a write strobe. The bus has no back-pressure: a write is taken on every rising clock edge where the strobe is high. Settings are staged. Each counter copies its new value only at a frame rollover, so a frame already under way finishes with the values it started with. An enable input stops everything: while it is low, all counters sit at zero and both outputs are low. The first rising edge that sees it high starts a fresh frame.

Top module: `pulse_frame_engine`

## Requirements
- R1: A synchronous reset drives both outputs low and loads the setting registers with period 4, length 2 and trigger delay 1.
- R2: A strobed write to word address 0 sets the period, address 1 sets the length and address 2 sets the trigger delay. A write to address 3 changes no setting.
- R3: A frame lasts exactly P clocks, where P is the period setting (0 is treated as 1). The output rises at every rollover when the length is non-zero.
- R4: When the length L satisfies 0 < L < P, the output stays high for exactly L clocks after the rollover and then goes low.
- R5: A length of zero keeps the output low for the entire frame.
- R6: A length greater than or equal to the period keeps the output high for the whole frame, so the output is high continuously.
- R7: The trigger rises at each rollover and falls D clocks later, where D is the delay setting. D = 0 behaves as D = 1. When D >= P, the trigger stays high for the whole frame.
- R8: A setting written during a frame takes effect only from the next rollover onward.
- R9: While enable is low, both outputs are low one clock later. The first clock edge that samples enable high starts a new frame.
- R10: With period 4, length 2 and delay 1, the output repeats the pattern high, high, low, low and the trigger repeats high, low, low, low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock from the external synthesizer |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run control; low holds the counters at zero and the outputs low |
| host_wr | input | 1 | Write strobe for the setting bus |
| host_addr | input | 2 | Setting word address |
| host_wdata | input | 32 | Setting write data |
| pulse_out | output | 1 | Main pulse output |
| trig_out | output | 1 | Trigger output; its falling edge marks the programmed delay |

## Verification
The assertions check on every cycle that:
- the frame position never passes the active period;
- a low enable silences both outputs on the next clock;
- a rollover raises each output that is armed, and a zero length keeps the output low;
- no output falls before its count is reached;
- a write to the spare address leaves all settings unchanged.

Only the bench scenarios can show that a frame has the right overall shape. That covers the exact reference waveform, the edge cases of length and delay against the period, and a write made in the middle of a frame that must wait for the next rollover.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_LENGTH = 2'd1,
    SEL_DELAY  = 2'd2,
    SEL_SPARE  = 2'd3
  } setting_sel_e;

  localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/pfe_settings.sv
module pfe_settings
  import pfe_pkg::*;
#(
  parameter int unsigned          W       = 32,
  parameter logic [W-1:0]         DEF_PER = 4,
  parameter logic [W-1:0]         DEF_LEN = 2,
  parameter logic [W-1:0]         DEF_DLY = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [SEL_W-1:0] addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     period,
  output logic [W-1:0]     length,
  output logic [W-1:0]     delay
);
  setting_sel_e sel;
  assign sel = setting_sel_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= DEF_PER;
      length <= DEF_LEN;
      delay  <= DEF_DLY;
    end else if (wr) begin
      case (sel)
        SEL_PERIOD: period <= wdata;
        SEL_LENGTH: length <= wdata;
        SEL_DELAY:  delay  <= wdata;
        default:    ;
      endcase
    end
  end

  // R2: the spare address leaves every setting untouched
  p_spare_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_SPARE) |=> ($stable(period) && $stable(length) && $stable(delay)));

  // R2: a length write lands in the length register
  p_length_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_LENGTH) |=> (length == $past(wdata)));
endmodule

// File: rtl/pfe_frame.sv
module pfe_frame #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic [W-1:0] period_in,
  output logic         start
);
  logic [W-1:0] pos;
  logic [W-1:0] per_q;
  logic [W-1:0] per_eff;
  logic         running;

  assign per_eff = (per_q == '0) ? {{(W-1){1'b0}}, 1'b1} : per_q;
  assign start   = enable && (!running || (pos >= per_eff - 1'b1));

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      pos     <= '0;
      per_q   <= '0;
      running <= 1'b0;
    end else if (start) begin
      pos     <= '0;
      per_q   <= period_in;
      running <= 1'b1;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  // R3: the frame position always stays inside the active period
  p_pos_bound_r3: assert property (@(posedge clk) disable iff (rst)
    running |-> (pos < per_eff));

  // R9: disabling parks the frame counter at zero
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (pos == '0 && !running));
endmodule

// File: rtl/pfe_match.sv
module pfe_match #(
  parameter int unsigned W           = 32,
  parameter bit          ZERO_AS_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         start,
  input  logic [W-1:0] target_in,
  output logic         level
);
  logic [W-1:0] tgt_q;
  logic [W-1:0] tgt_eff;
  logic [W-1:0] cnt;
  logic         arm;

  generate
    if (ZERO_AS_ONE) begin : g_min_one
      assign tgt_eff = (tgt_q == '0) ? {{(W-1){1'b0}}, 1'b1} : tgt_q;
      assign arm     = 1'b1;
    end else begin : g_zero_off
      assign tgt_eff = tgt_q;
      assign arm     = (target_in != '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      tgt_q <= '0;
      cnt   <= '0;
      level <= 1'b0;
    end else if (start) begin
      tgt_q <= target_in;
      cnt   <= {{(W-1){1'b0}}, 1'b1};
      level <= arm;
    end else if (level) begin
      if (cnt >= tgt_eff) level <= 1'b0;
      else                cnt   <= cnt + 1'b1;
    end
  end

  // R9: hold forces the level low on the next clock
  p_hold_low_r9: assert property (@(posedge clk) disable iff (rst)
    hold |=> !level);

  // R3: a rollover raises an armed level
  p_start_rises_r3: assert property (@(posedge clk) disable iff (rst)
    (start && arm && !hold) |=> level);

  // R5: an unarmed rollover leaves the level low
  p_zero_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (start && !arm && !hold) |=> !level);

  // R4: no fall before the programmed count is reached
  p_no_early_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (level && !start && !hold && (cnt < tgt_eff)) |=> level);
endmodule

// File: rtl/pulse_frame_engine.sv
module pulse_frame_engine
  import pfe_pkg::*;
#(
  parameter int unsigned  W       = 32,
  parameter logic [W-1:0] DEF_PER = 4,
  parameter logic [W-1:0] DEF_LEN = 2,
  parameter logic [W-1:0] DEF_DLY = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             host_wr,
  input  logic [SEL_W-1:0] host_addr,
  input  logic [W-1:0]     host_wdata,
  output logic             pulse_out,
  output logic             trig_out
);
  logic [W-1:0] set_period;
  logic [W-1:0] set_length;
  logic [W-1:0] set_delay;
  logic         frame_start;

  pfe_settings #(.W(W), .DEF_PER(DEF_PER), .DEF_LEN(DEF_LEN), .DEF_DLY(DEF_DLY)) u_settings (
    .clk    (clk),
    .rst    (rst),
    .wr     (host_wr),
    .addr   (host_addr),
    .wdata  (host_wdata),
    .period (set_period),
    .length (set_length),
    .delay  (set_delay)
  );

  pfe_frame #(.W(W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .period_in (set_period),
    .start     (frame_start)
  );

  pfe_match #(.W(W), .ZERO_AS_ONE(1'b0)) u_length (
    .clk       (clk),
    .rst       (rst),
    .hold      (!enable),
    .start     (frame_start),
    .target_in (set_length),
    .level     (pulse_out)
  );

  pfe_match #(.W(W), .ZERO_AS_ONE(1'b1)) u_delay (
    .clk       (clk),
    .rst       (rst),
    .hold      (!enable),
    .start     (frame_start),
    .target_in (set_delay),
    .level     (trig_out)
  );

  // R9: both outputs go quiet one clock after enable drops
  p_idle_out_r9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!pulse_out && !trig_out));

  // R7: each rollover raises the trigger
  p_trig_rise_r7: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> trig_out);
endmodule

// File: tb/pulse_frame_engine_test.sv
module pulse_frame_engine_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         enable = 1'b0;
  logic         host_wr = 1'b0;
  logic [1:0]   host_addr = '0;
  logic [W-1:0] host_wdata = '0;
  logic         pulse_out;
  logic         trig_out;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic  p;
    logic  t;
    string tag;
  } exp_t;
  exp_t sb[$];

  pulse_frame_engine #(.W(W)) uut (
    .clk(clk), .rst(rst), .enable(enable), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .pulse_out(pulse_out), .trig_out(trig_out)
  );

  always #5 clk = ~clk;

  // monitor: compare each expected cycle away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      tests++;
      if (pulse_out !== e.p || trig_out !== e.t) begin
        fails++;
        $display("FAIL %s: pulse/trig = %b/%b expected %b/%b", e.tag, pulse_out, trig_out, e.p, e.t);
      end
    end
  end

  function automatic void push_item(logic p, logic t, string tag);
    exp_t e;
    e.p = p; e.t = t; e.tag = tag;
    sb.push_back(e);
  endfunction

  function automatic int push_frames(int p, int l, int d, int n, string tag);
    int pe = (p == 0) ? 1 : p;
    int de = (d == 0) ? 1 : d;
    for (int f = 0; f < n; f++)
      for (int k = 0; k < pe; k++)
        push_item((l != 0) && (k < l), k < de, tag);
    return n * pe;
  endfunction

  task automatic write_reg(logic [1:0] a, logic [W-1:0] d);
    @(posedge clk); #1;
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic stop_run();
    enable = 1'b0;
    push_item(1'b0, 1'b0, "R9 idle after disable");
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic run_frames(int p, int l, int d, int n, string tag);
    int cyc;
    @(posedge clk); #1;
    enable = 1'b1;
    push_item(1'b0, 1'b0, "R9 idle before first edge");
    cyc = push_frames(p, l, d, n, tag);
    repeat (cyc) @(posedge clk);
    #1;
    stop_run();
  endtask

  initial begin
    @(posedge clk); #4;
    tests++;
    if (pulse_out !== 1'b0 || trig_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset outputs %b/%b expected 0/0", pulse_out, trig_out);
    end
    @(posedge clk); #1;
    rst = 1'b0;

    // R1 and R10: default settings give the reference waveform
    run_frames(4, 2, 1, 3, "R1/R10 reference 4-2-1");

    // R3, R4, R7: general frame
    write_reg(2'd0, 7); write_reg(2'd1, 3); write_reg(2'd2, 5);
    run_frames(7, 3, 5, 2, "R3/R4/R7 period 7");

    // R5 zero length, R7 zero delay acts as one
    write_reg(2'd0, 5); write_reg(2'd1, 0); write_reg(2'd2, 0);
    run_frames(5, 0, 0, 2, "R5/R7 zero length, zero delay");

    // R6 length beyond period, R7 delay equal to period
    write_reg(2'd0, 6); write_reg(2'd1, 9); write_reg(2'd2, 6);
    run_frames(6, 9, 6, 2, "R6/R7 long length and delay");

    // R3 single-cycle period
    write_reg(2'd0, 1); write_reg(2'd1, 1); write_reg(2'd2, 1);
    run_frames(1, 1, 1, 4, "R3 period one");

    // R2: spare address write must not disturb any setting
    write_reg(2'd3, 32'h0000_0002);
    run_frames(1, 1, 1, 3, "R2 spare address ignored");

    // R8: writes in mid-frame apply only from the next rollover
    write_reg(2'd0, 4); write_reg(2'd1, 2); write_reg(2'd2, 1);
    begin
      int cyc;
      @(posedge clk); #1;
      enable = 1'b1;
      push_item(1'b0, 1'b0, "R9 idle before first edge");
      cyc = push_frames(4, 2, 1, 1, "R8 old frame kept");
      cyc += push_frames(6, 1, 3, 2, "R8 new values after rollover");
      @(posedge clk); #1; host_wr = 1'b1; host_addr = 2'd0; host_wdata = 6;
      @(posedge clk); #1; host_addr = 2'd1; host_wdata = 1;
      @(posedge clk); #1; host_addr = 2'd2; host_wdata = 3;
      @(posedge clk); #1; host_wr = 1'b0;
      repeat (cyc - 4) @(posedge clk);
      #1;
      stop_run();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule